// File: doc/BRIEF.md
# Dual-Direction Mailbox Bypass Registers

This block carries short command words between two ports that run on unrelated clocks, alongside and independent of any bulk data queue. It holds two 36-bit mailboxes. Port A writes mailbox 1 and port B reads it. Port B writes mailbox 2 and port A reads it. Each writing port sees an active-low flag for its outbound mailbox. The flag goes low when a write is accepted and stays low until the opposite port has read the word. While the flag is low, further writes to that mailbox are dropped, so an unread word is never overwritten.

The flag lives in the writer's clock domain. A write flips a write toggle. The reader sees that toggle through a two-flop synchronizer and counts the word as unread. The reader's first read of an unread word flips a read toggle, which returns to the writer through another two-flop synchronizer and raises the flag again. Reads copy the mailbox into a registered output on the reading port and never change the mailbox itself. Reads of a mailbox with no unread word still return its contents but have no effect on the handshake.

Port A selects a mailbox access with its mailbox-select input. Port B selects one when both of its size-select inputs are high, the code that the rest of the chip reserves for mailbox traffic. Each port has its own synchronous active-high reset.

Top module: `mbox_bridge`

## Requirements
- R1: After reset both flags (`a_full_n`, `b_full_n`) are 1 and both data outputs are zero.
- R2: On a rising `clk_a` edge with `a_cs_n`=0, `a_en`=1, `a_msel`=1 and `a_wr`=1, while `a_full_n` is 1, `a_din` is stored in mailbox 1 and `a_full_n` reads 0 after that edge; with `a_msel`=0 the same cycle has no effect on the flag.
- R3: On a rising `clk_b` edge with `b_cs_n`=0, `b_en`=1, `b_siz`=2'b11 and `b_wr`=1, while `b_full_n` is 1, `b_din` is stored in mailbox 2 and `b_full_n` reads 0 after that edge; any other `b_siz` value leaves the flag unchanged.
- R4: A write to a mailbox whose flag is 0 is dropped: the flag stays 0 and the stored word is unchanged.
- R5: A read (`a_wr`=0 or `b_wr`=0 with the same select terms as R2/R3) loads the opposite mailbox into the reading port's data output at that edge; without a read the output holds its value.
- R6: Reads never alter a mailbox; a repeated read returns the same word.
- R7: After the reader's first read of an unread word, the writer's flag returns to 1 within a few writer clock edges (two synchronizer stages).
- R8: Without a read, a flag that is 0 stays 0 for any number of cycles.
- R9: A read of a mailbox with no unread word has no effect on either flag, and the handshake still works for the next write.
- R10: The two mailboxes are independent: traffic on one never changes the flag or contents of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A access enable |
| a_msel | input | 1 | Port A mailbox select |
| a_din | input | 36 | Word written to mailbox 1 |
| a_dout | output | 36 | Registered word read from mailbox 2 |
| a_full_n | output | 1 | Mailbox 1 flag, 0 while unread |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B access enable |
| b_siz | input | 2 | Port B size select; 2'b11 selects the mailbox |
| b_din | input | 36 | Word written to mailbox 2 |
| b_dout | output | 36 | Registered word read from mailbox 1 |
| b_full_n | output | 1 | Mailbox 2 flag, 0 while unread |

## Verification
The hardest state to reach from the ports is the one where the reader has not yet consumed a word and the writer tries again, because the window depends on how the two unrelated clocks line up with the synchronizers. The bench reaches it by issuing a second write on the very next port A cycle after the first, long before any read can have crossed back, and then proves from the reader's output that the first word survived. It also reads a mailbox that holds no unread word before and after a complete exchange, then runs a fresh exchange, to show the handshake parity was not disturbed.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MB_DATA_W   = 36;
  localparam int unsigned MB_SYNC_LEN = 2;
  localparam int unsigned MB_CHANNELS = 2;

  // channel index: 0 carries port A -> port B, 1 carries port B -> port A
  typedef enum logic [0:0] {
    CH_A_TO_B = 1'b0,
    CH_B_TO_A = 1'b1
  } mb_chan_e;

  // size-select code on port B that means mailbox traffic
  localparam logic [1:0] MB_SIZ_MAILBOX = 2'b11;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_tx.sv
// Writer side of one mailbox: holds the word, the write toggle and the flag.
module mbox_tx #(
  parameter int unsigned DW     = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] din,
  input  logic          rd_tgl_far,
  output logic          full_n,
  output logic          wr_tgl,
  output logic [DW-1:0] word_q
);
  logic tgl_q;
  logic ack_s;
  logic accept;

  mbox_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (rd_tgl_far),
    .q   (ack_s)
  );

  // equal toggles: every accepted word has been acknowledged
  assign full_n = ~(tgl_q ^ ack_s);
  assign accept = wr_req & full_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q  <= 1'b0;
      word_q <= '0;
    end else if (accept) begin
      tgl_q  <= ~tgl_q;
      word_q <= din;
    end
  end

  assign wr_tgl = tgl_q;
endmodule

// File: rtl/mbox_rx.sv
// Reader side of one mailbox: tracks an unread word and returns the read toggle.
module mbox_rx #(
  parameter int unsigned DW     = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          wr_tgl_far,
  input  logic [DW-1:0] word_far,
  output logic [DW-1:0] dout,
  output logic          rd_tgl
);
  logic wr_s;
  logic tgl_q;
  logic unread;

  mbox_sync #(.STAGES(STAGES)) u_wr_sync (
    .clk (clk),
    .rst (rst),
    .d   (wr_tgl_far),
    .q   (wr_s)
  );

  assign unread = wr_s ^ tgl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q <= 1'b0;
      dout  <= '0;
    end else if (rd_req) begin
      dout <= word_far;
      if (unread) tgl_q <= ~tgl_q;
    end
  end

  assign rd_tgl = tgl_q;
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int unsigned DW     = MB_DATA_W,
  parameter int unsigned STAGES = MB_SYNC_LEN
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic          a_en,
  input  logic          a_msel,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic          a_full_n,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          b_cs_n,
  input  logic          b_wr,
  input  logic          b_en,
  input  logic [1:0]    b_siz,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic          b_full_n
);
  localparam int unsigned NCH = MB_CHANNELS;

  logic a_sel, b_sel;
  logic [NCH-1:0]         w_clk, w_rst, r_clk, r_rst;
  logic [NCH-1:0]         wr_req, rd_req, full_n, wr_tgl, rd_tgl;
  logic [NCH-1:0][DW-1:0] din, mb_q, rx_dout;

  assign a_sel = ~a_cs_n & a_en & a_msel;
  assign b_sel = ~b_cs_n & b_en & (b_siz == MB_SIZ_MAILBOX);

  // channel A->B: port A writes, port B reads
  assign w_clk[CH_A_TO_B]  = clk_a;
  assign w_rst[CH_A_TO_B]  = rst_a;
  assign r_clk[CH_A_TO_B]  = clk_b;
  assign r_rst[CH_A_TO_B]  = rst_b;
  assign wr_req[CH_A_TO_B] = a_sel & a_wr;
  assign rd_req[CH_A_TO_B] = b_sel & ~b_wr;
  assign din[CH_A_TO_B]    = a_din;

  // channel B->A: port B writes, port A reads
  assign w_clk[CH_B_TO_A]  = clk_b;
  assign w_rst[CH_B_TO_A]  = rst_b;
  assign r_clk[CH_B_TO_A]  = clk_a;
  assign r_rst[CH_B_TO_A]  = rst_a;
  assign wr_req[CH_B_TO_A] = b_sel & b_wr;
  assign rd_req[CH_B_TO_A] = a_sel & ~a_wr;
  assign din[CH_B_TO_A]    = b_din;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mbox_tx #(.DW(DW), .STAGES(STAGES)) u_tx (
      .clk        (w_clk[c]),
      .rst        (w_rst[c]),
      .wr_req     (wr_req[c]),
      .din        (din[c]),
      .rd_tgl_far (rd_tgl[c]),
      .full_n     (full_n[c]),
      .wr_tgl     (wr_tgl[c]),
      .word_q     (mb_q[c])
    );

    mbox_rx #(.DW(DW), .STAGES(STAGES)) u_rx (
      .clk        (r_clk[c]),
      .rst        (r_rst[c]),
      .rd_req     (rd_req[c]),
      .wr_tgl_far (wr_tgl[c]),
      .word_far   (mb_q[c]),
      .dout       (rx_dout[c]),
      .rd_tgl     (rd_tgl[c])
    );
  end

  assign a_full_n = full_n[CH_A_TO_B];
  assign b_full_n = full_n[CH_B_TO_A];
  assign b_dout   = rx_dout[CH_A_TO_B];
  assign a_dout   = rx_dout[CH_B_TO_A];
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk_a,
  input logic          rst_a,
  input logic          a_cs_n,
  input logic          a_wr,
  input logic          a_en,
  input logic          a_msel,
  input logic [DW-1:0] a_dout,
  input logic          a_full_n,
  input logic          clk_b,
  input logic          rst_b,
  input logic          b_cs_n,
  input logic          b_wr,
  input logic          b_en,
  input logic [1:0]    b_siz,
  input logic [DW-1:0] b_dout,
  input logic          b_full_n,
  input logic [DW-1:0] m1_q,
  input logic [DW-1:0] m2_q
);
  logic a_acc, b_acc;
  assign a_acc = ~a_cs_n & a_en & a_msel;
  assign b_acc = ~b_cs_n & b_en & (b_siz == 2'b11);

  p_flag_low_after_write_r2: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_acc && a_wr && a_full_n) |=> !a_full_n);

  p_flag_low_after_write_r3: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_acc && b_wr && b_full_n) |=> !b_full_n);

  p_no_overwrite_m1_r4: assert property (@(posedge clk_a) disable iff (rst_a)
    !a_full_n |=> $stable(m1_q));

  p_no_overwrite_m2_r4: assert property (@(posedge clk_b) disable iff (rst_b)
    !b_full_n |=> $stable(m2_q));

  p_dout_hold_a_r5: assert property (@(posedge clk_a) disable iff (rst_a)
    !(a_acc && !a_wr) |=> $stable(a_dout));

  p_dout_hold_b_r5: assert property (@(posedge clk_b) disable iff (rst_b)
    !(b_acc && !b_wr) |=> $stable(b_dout));

  p_fall_needs_write_a_r8: assert property (@(posedge clk_a) disable iff (rst_a)
    $fell(a_full_n) |-> $past(a_acc && a_wr));

  p_fall_needs_write_b_r8: assert property (@(posedge clk_b) disable iff (rst_b)
    $fell(b_full_n) |-> $past(b_acc && b_wr));
endmodule

bind mbox_bridge mbox_bridge_chk #(.DW(DW)) u_chk (
  .clk_a    (clk_a),
  .rst_a    (rst_a),
  .a_cs_n   (a_cs_n),
  .a_wr     (a_wr),
  .a_en     (a_en),
  .a_msel   (a_msel),
  .a_dout   (a_dout),
  .a_full_n (a_full_n),
  .clk_b    (clk_b),
  .rst_b    (rst_b),
  .b_cs_n   (b_cs_n),
  .b_wr     (b_wr),
  .b_en     (b_en),
  .b_siz    (b_siz),
  .b_dout   (b_dout),
  .b_full_n (b_full_n),
  .m1_q     (mb_q[0]),
  .m2_q     (mb_q[1])
);

// File: tb/sim_mbox_bridge.sv
`timescale 1ns/1ps
module sim_mbox_bridge;
  localparam int DW = 36;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_msel = 1'b0;
  logic b_cs_n = 1'b1, b_wr = 1'b0, b_en = 1'b0;
  logic [1:0] b_siz = 2'b00;
  logic [DW-1:0] a_din = '0, b_din = '0;
  logic [DW-1:0] a_dout, b_dout;
  logic a_full_n, b_full_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4   clk_a = ~clk_a;   // 125 MHz
  always #6.5 clk_b = ~clk_b;   // unrelated port B clock

  mbox_bridge u0 (
    .clk_a(clk_a), .rst_a(rst_a), .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en),
    .a_msel(a_msel), .a_din(a_din), .a_dout(a_dout), .a_full_n(a_full_n),
    .clk_b(clk_b), .rst_b(rst_b), .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en),
    .b_siz(b_siz), .b_din(b_din), .b_dout(b_dout), .b_full_n(b_full_n)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_a(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_a);
  endtask

  task automatic wait_b(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_b);
  endtask

  // one port A cycle; returns after the edge, at the following negedge
  task automatic a_cycle(input logic wr, input logic msel, input logic [DW-1:0] d);
    @(negedge clk_a);
    a_cs_n = 1'b0; a_en = 1'b1; a_wr = wr; a_msel = msel; a_din = d;
    @(negedge clk_a);
    a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0; a_msel = 1'b0;
  endtask

  task automatic b_cycle(input logic wr, input logic [1:0] siz, input logic [DW-1:0] d);
    @(negedge clk_b);
    b_cs_n = 1'b0; b_en = 1'b1; b_wr = wr; b_siz = siz; b_din = d;
    @(negedge clk_b);
    b_cs_n = 1'b1; b_en = 1'b0; b_wr = 1'b0; b_siz = 2'b00;
  endtask

  task automatic t_reset();
    chk("R1 a_full_n", a_full_n, 1);
    chk("R1 b_full_n", b_full_n, 1);
    chk("R1 a_dout", a_dout, '0);
    chk("R1 b_dout", b_dout, '0);
  endtask

  task automatic t_a_to_b();
    a_cycle(1'b1, 1'b1, 36'h1_2345_6789);
    chk("R2 a_full_n low after write", a_full_n, 0);
    chk("R10 b_full_n untouched", b_full_n, 1);
    wait_b(5);
    b_cycle(1'b0, 2'b11, '0);
    chk("R5 b_dout after read", b_dout, 36'h1_2345_6789);
    wait_a(6);
    chk("R7 a_full_n high after read", a_full_n, 1);
  endtask

  task automatic t_drop_second_write();
    a_cycle(1'b1, 1'b1, 36'hA_AAAA_0001);
    a_cycle(1'b1, 1'b1, 36'h5_5555_0002);
    chk("R4 flag still low after dropped write", a_full_n, 0);
    wait_b(5);
    b_cycle(1'b0, 2'b11, '0);
    chk("R4 first word kept", b_dout, 36'hA_AAAA_0001);
    wait_a(6);
    chk("R7 flag high after read", a_full_n, 1);
    b_cycle(1'b0, 2'b11, '0);
    chk("R6 repeat read same word", b_dout, 36'hA_AAAA_0001);
    wait_a(6);
    chk("R9 read with nothing unread leaves flag", a_full_n, 1);
  endtask

  task automatic t_hold_without_read();
    a_cycle(1'b1, 1'b1, 36'h0_0BAD_F00D);
    wait_a(40);
    chk("R8 flag stays low with no read", a_full_n, 0);
    b_cycle(1'b0, 2'b11, '0);
    chk("R5 b_dout", b_dout, 36'h0_0BAD_F00D);
    wait_a(6);
    chk("R7 flag high", a_full_n, 1);
  endtask

  task automatic t_b_to_a();
    b_cycle(1'b1, 2'b11, 36'hF_0F0F_1234);
    chk("R3 b_full_n low after write", b_full_n, 0);
    chk("R10 a_full_n untouched", a_full_n, 1);
    chk("R10 b_dout untouched", b_dout, 36'h0_0BAD_F00D);
    wait_a(6);
    a_cycle(1'b0, 1'b1, '0);
    chk("R5 a_dout after read", a_dout, 36'hF_0F0F_1234);
    wait_b(6);
    chk("R7 b_full_n high", b_full_n, 1);
  endtask

  task automatic t_decode();
    a_cycle(1'b1, 1'b0, 36'h7_7777_7777);
    chk("R2 msel low write ignored", a_full_n, 1);
    b_cycle(1'b1, 2'b01, 36'h3_3333_3333);
    chk("R3 non-mailbox size ignored", b_full_n, 1);
    a_cycle(1'b0, 1'b0, '0);
    chk("R5 msel low read holds a_dout", a_dout, 36'hF_0F0F_1234);
    b_cycle(1'b0, 2'b10, '0);
    chk("R5 non-mailbox read holds b_dout", b_dout, 36'h0_0BAD_F00D);
    wait_b(5);
    b_cycle(1'b0, 2'b11, '0);
    chk("R2 mailbox 1 not written by msel low", b_dout, 36'h0_0BAD_F00D);
  endtask

  task automatic t_idle_reads_then_exchange();
    b_cycle(1'b0, 2'b11, '0);
    b_cycle(1'b0, 2'b11, '0);
    a_cycle(1'b0, 1'b1, '0);
    wait_a(6);
    chk("R9 idle reads keep a flag", a_full_n, 1);
    chk("R9 idle reads keep b flag", b_full_n, 1);
    a_cycle(1'b1, 1'b1, 36'hC_AFE0_0042);
    chk("R9 write after idle reads", a_full_n, 0);
    wait_b(5);
    b_cycle(1'b0, 2'b11, '0);
    chk("R9 read after idle reads", b_dout, 36'hC_AFE0_0042);
    wait_a(6);
    chk("R9 flag returns after exchange", a_full_n, 1);
  endtask

  initial begin
    wait_b(6);
    rst_a = 1'b0; rst_b = 1'b0;
    wait_b(2);
    t_reset();
    t_a_to_b();
    t_drop_second_write();
    t_hold_without_read();
    t_b_to_a();
    t_decode();
    t_idle_reads_then_exchange();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule